// File: doc/BRIEF.md
# DDR2 Command Spacing Checker

This block watches the command bus of a DDR2 memory controller and reports any command that arrives too soon after an earlier command it depends on. Each command the controller issues is presented as a code with a valid strobe, together with a bank number, the CKE pin level, the programmed additive latency and the power-down exit mode. The checker keeps one down-counter for each spacing rule (and one for each bank where the rule is per bank). On the cycle an offending command is presented, it raises the bit for the broken rule. Each rule window is a number of clocks. Windows given in time are converted to clocks when the design is built: the time limit is divided by the clock-period parameter and rounded up. The default clock period is 3.75 ns.

The block is a passive monitor. The command input has no back-pressure: a command strobed with `cmd_valid` is always taken and always evaluated. The `ready_mask` output is advisory. For each command code, it shows whether that command would pass every rule if it were presented in the current cycle, using the bank currently on `cmd_bank`. A controller can use this mask to choose its next command. Counters load on every matching command, including one that has just been flagged.

Top module: `ddr2_cmd_spacing_chk`

## Requirements
- R1: After reset, `viol` is all zero and every bit of `ready_mask` is one, with no counters running.
- R2: The command codes are NOP=0, ACT=1, READ=2, WRITE=3, WRITE-with-auto-precharge=4, PRE=5, REF=6, self-refresh entry=7, self-refresh exit=8, power-down entry=9 and power-down exit=10. The violation bits are: 0 write-to-read, 1 read-to-precharge, 2 auto-precharge-to-activate, 3 refresh, 4 self-refresh-exit non-read, 5 self-refresh-exit read, 6 precharge power-down exit, 7 active power-down exit read, 8 CKE pulse width. Bits 0 to 7 are asserted only in a cycle where `cmd_valid` is high.
- R3: A READ that comes fewer than ceil(7.5 ns / tCK) clocks after a WRITE or a WRITE-with-auto-precharge sets bit 0. The default is 2 clocks.
- R4: A PRE that comes fewer than ceil(7.5 ns / tCK) clocks after a READ sets bit 1. The default is 2 clocks.
- R5: An ACT to bank b that comes fewer than ceil(tWR/tCK)+ceil(tRP/tCK) clocks after a WRITE-with-auto-precharge to the same bank b sets bit 2. The default is 4+4=8 clocks. An ACT to a different bank is not affected.
- R6: An ACT or a REF that comes fewer than ceil(105 ns / tCK) clocks after a REF sets bit 3. The default is 28 clocks.
- R7: A non-read command (ACT, WRITE, WRITE-with-auto-precharge, PRE, REF, self-refresh entry, power-down entry) that comes fewer than ceil((tRFC+10 ns)/tCK) clocks after a self-refresh exit sets bit 4. The default is 31 clocks.
- R8: A READ that comes fewer than 200 clocks after a self-refresh exit sets bit 5.
- R9: A power-down exit while no bank is open is a precharge power-down exit. After it, a non-read command that comes fewer than 2 clocks later sets bit 6.
- R10: ACT marks a bank open. PRE or WRITE-with-auto-precharge marks it closed. A power-down exit while any bank is open is an active power-down exit. After it, a READ sets bit 7 if it comes fewer than 2 clocks later when `pd_slow_exit`=0, or fewer than max(6−AL, 0) clocks later when `pd_slow_exit`=1. AL is taken from `add_lat` at the exit.
- R11: A change of `cke` less than 3 clocks after the previous change sets bit 8 in the cycle of the change, whatever the state of `cmd_valid`.
- R12: `ready_mask[c]` is zero exactly when a command with code c, presented in the current cycle (with the current `cmd_bank`), would set one of bits 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 4 | Command code (see R2) |
| cmd_bank | input | BANK_W (3) | Bank addressed by the command |
| cke | input | 1 | Level of the CKE pin |
| add_lat | input | AL_W (3) | Programmed additive latency |
| pd_slow_exit | input | 1 | 1 selects slow (low-power) active power-down exit timing |
| viol | output | 9 | One bit per rule, pulsed in the cycle of the offence |
| ready_mask | output | 11 | One bit per command code: 1 when that command may issue now |

## Verification
The hardest case to reach is the read after an active power-down exit. It needs a bank left open, the exit mode and additive latency set, and a power-down exit issued. Only after all of that does the read window, which depends on latency, apply. The bench opens bank 0 with an ACT and lets every counter drain. It then issues the exit in fast mode and in slow mode with several latency values, including one large enough that no wait is left. The 200-clock read window after a self-refresh exit is checked at clock 199 and at clock 200. At clock 199 the shorter non-read window has already closed, so bit 5 can only be set on its own.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;

  localparam int CMD_W     = 4;
  localparam int NUM_CMDS  = 11;
  localparam int NUM_RULES = 9;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 4'd0,
    CMD_ACT = 4'd1,
    CMD_RD  = 4'd2,
    CMD_WR  = 4'd3,
    CMD_WRA = 4'd4,
    CMD_PRE = 4'd5,
    CMD_REF = 4'd6,
    CMD_SRE = 4'd7,
    CMD_SRX = 4'd8,
    CMD_PDE = 4'd9,
    CMD_PDX = 4'd10
  } cmd_e;

  localparam int R_WTR  = 0;
  localparam int R_RTP  = 1;
  localparam int R_DAL  = 2;
  localparam int R_RFC  = 3;
  localparam int R_XSNR = 4;
  localparam int R_XSRD = 5;
  localparam int R_XP   = 6;
  localparam int R_XARD = 7;
  localparam int R_CKE  = 8;

  typedef struct packed {
    logic wtr;
    logic rtp;
    logic dal;
    logic rfc;
    logic xsnr;
    logic xsrd;
    logic xp;
    logic xard;
  } busy_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Value loaded into a down-counter so that it reads non-zero for n-1 cycles.
  function automatic int load_of(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int cnt_width(input int n);
    return ($clog2(n + 1) < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic logic is_non_read(input cmd_e c);
    return c inside {CMD_ACT, CMD_WR, CMD_WRA, CMD_PRE, CMD_REF, CMD_SRE, CMD_PDE};
  endfunction

  // Rules (bits 0..7) that command c would break given the current busy state.
  function automatic logic [NUM_RULES-1:0] rule_hits(input cmd_e c, input busy_t b);
    logic [NUM_RULES-1:0] r;
    r         = '0;
    r[R_WTR]  = (c == CMD_RD) && b.wtr;
    r[R_RTP]  = (c == CMD_PRE) && b.rtp;
    r[R_DAL]  = (c == CMD_ACT) && b.dal;
    r[R_RFC]  = ((c == CMD_ACT) || (c == CMD_REF)) && b.rfc;
    r[R_XSNR] = is_non_read(c) && b.xsnr;
    r[R_XSRD] = (c == CMD_RD) && b.xsrd;
    r[R_XP]   = is_non_read(c) && b.xp;
    r[R_XARD] = (c == CMD_RD) && b.xard;
    return r;
  endfunction

endpackage

// File: rtl/ddr2_spacing_timer.sv
module ddr2_spacing_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (load)            remain <= load_val;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker #(
  parameter int BANK_W = 3,
  parameter int N_DAL  = 8,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int W_DAL     = ddr2_chk_pkg::cnt_width(N_DAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_fire,
  input  logic              pre_fire,
  input  logic              wra_fire,
  input  logic [BANK_W-1:0] bank,
  output logic              dal_busy,
  output logic              any_open
);

  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] busy_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
    end else if (act_fire) begin
      open_q[bank] <= 1'b1;
    end else if (pre_fire || wra_fire) begin
      open_q[bank] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr2_spacing_timer #(.CNT_W(W_DAL)) u_dal (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wra_fire && (bank == BANK_W'(b))),
      .load_val (W_DAL'(ddr2_chk_pkg::load_of(N_DAL))),
      .busy     (busy_vec[b])
    );
  end

  assign dal_busy = busy_vec[bank];
  assign any_open = |open_q;

endmodule

// File: rtl/ddr2_cke_monitor.sv
module ddr2_cke_monitor #(
  parameter int N_CKE = 3,
  localparam int W_CKE = ddr2_chk_pkg::cnt_width(N_CKE)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic pulse_viol
);

  logic cke_q;
  logic toggled;
  logic busy;

  always_ff @(posedge clk) cke_q <= cke;

  assign toggled = rst_n && (cke != cke_q);

  ddr2_spacing_timer #(.CNT_W(W_CKE)) u_width (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (toggled),
    .load_val (W_CKE'(ddr2_chk_pkg::load_of(N_CKE))),
    .busy     (busy)
  );

  assign pulse_viol = toggled && busy;

endmodule

// File: rtl/ddr2_cmd_spacing_chk.sv
module ddr2_cmd_spacing_chk
  import ddr2_chk_pkg::*;
#(
  parameter int TCK_PS             = 3750,
  parameter int T_WTR_PS           = 7500,
  parameter int T_RTP_PS           = 7500,
  parameter int T_WR_PS            = 15000,
  parameter int T_RP_PS            = 15000,
  parameter int T_RFC_PS           = 105000,
  parameter int T_XS_EXTRA_PS      = 10000,
  parameter int XSRD_CK            = 200,
  parameter int XP_CK              = 2,
  parameter int XARD_FAST_CK       = 2,
  parameter int XARD_SLOW_BASE_CK  = 6,
  parameter int CKE_CK             = 3,
  parameter int BANK_W             = 3,
  parameter int AL_W               = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_code,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cke,
  input  logic [AL_W-1:0]      add_lat,
  input  logic                 pd_slow_exit,
  output logic [NUM_RULES-1:0] viol,
  output logic [NUM_CMDS-1:0]  ready_mask
);

  localparam int N_WTR  = ceil_div(T_WTR_PS, TCK_PS);
  localparam int N_RTP  = ceil_div(T_RTP_PS, TCK_PS);
  localparam int N_DAL  = ceil_div(T_WR_PS, TCK_PS) + ceil_div(T_RP_PS, TCK_PS);
  localparam int N_RFC  = ceil_div(T_RFC_PS, TCK_PS);
  localparam int N_XSNR = ceil_div(T_RFC_PS + T_XS_EXTRA_PS, TCK_PS);
  localparam int N_XSRD = XSRD_CK;
  localparam int N_XP   = XP_CK;
  localparam int N_XARD = (XARD_SLOW_BASE_CK > XARD_FAST_CK) ? XARD_SLOW_BASE_CK : XARD_FAST_CK;

  localparam int W_WTR  = cnt_width(N_WTR);
  localparam int W_RTP  = cnt_width(N_RTP);
  localparam int W_RFC  = cnt_width(N_RFC);
  localparam int W_XSNR = cnt_width(N_XSNR);
  localparam int W_XSRD = cnt_width(N_XSRD);
  localparam int W_XP   = cnt_width(N_XP);
  localparam int W_XARD = cnt_width(N_XARD);

  cmd_e  cmd;
  busy_t busy;
  logic  fire_wr, fire_wra, fire_rd, fire_ref, fire_srx, fire_pdx, fire_act, fire_pre;
  logic  any_open;
  logic  cke_viol;
  int    xard_clocks;
  logic [W_XARD-1:0] xard_load;

  assign cmd      = cmd_e'(cmd_code);
  assign fire_act = cmd_valid && (cmd == CMD_ACT);
  assign fire_rd  = cmd_valid && (cmd == CMD_RD);
  assign fire_wra = cmd_valid && (cmd == CMD_WRA);
  assign fire_wr  = cmd_valid && ((cmd == CMD_WR) || (cmd == CMD_WRA));
  assign fire_pre = cmd_valid && (cmd == CMD_PRE);
  assign fire_ref = cmd_valid && (cmd == CMD_REF);
  assign fire_srx = cmd_valid && (cmd == CMD_SRX);
  assign fire_pdx = cmd_valid && (cmd == CMD_PDX);

  // Active power-down exit read window: fast, or slow reduced by additive latency.
  always_comb begin
    if (pd_slow_exit)
      xard_clocks = (XARD_SLOW_BASE_CK > int'(add_lat)) ? XARD_SLOW_BASE_CK - int'(add_lat) : 0;
    else
      xard_clocks = XARD_FAST_CK;
    xard_load = W_XARD'(load_of(xard_clocks));
  end

  ddr2_spacing_timer #(.CNT_W(W_WTR)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(fire_wr),
    .load_val(W_WTR'(load_of(N_WTR))), .busy(busy.wtr));

  ddr2_spacing_timer #(.CNT_W(W_RTP)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(fire_rd),
    .load_val(W_RTP'(load_of(N_RTP))), .busy(busy.rtp));

  ddr2_spacing_timer #(.CNT_W(W_RFC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(fire_ref),
    .load_val(W_RFC'(load_of(N_RFC))), .busy(busy.rfc));

  ddr2_spacing_timer #(.CNT_W(W_XSNR)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .load(fire_srx),
    .load_val(W_XSNR'(load_of(N_XSNR))), .busy(busy.xsnr));

  ddr2_spacing_timer #(.CNT_W(W_XSRD)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .load(fire_srx),
    .load_val(W_XSRD'(load_of(N_XSRD))), .busy(busy.xsrd));

  ddr2_spacing_timer #(.CNT_W(W_XP)) u_xp (
    .clk(clk), .rst_n(rst_n), .load(fire_pdx && !any_open),
    .load_val(W_XP'(load_of(N_XP))), .busy(busy.xp));

  ddr2_spacing_timer #(.CNT_W(W_XARD)) u_xard (
    .clk(clk), .rst_n(rst_n), .load(fire_pdx && any_open),
    .load_val(xard_load), .busy(busy.xard));

  ddr2_bank_tracker #(.BANK_W(BANK_W), .N_DAL(N_DAL)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_fire (fire_act),
    .pre_fire (fire_pre),
    .wra_fire (fire_wra),
    .bank     (cmd_bank),
    .dal_busy (busy.dal),
    .any_open (any_open)
  );

  ddr2_cke_monitor #(.N_CKE(CKE_CK)) u_cke (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .pulse_viol (cke_viol)
  );

  always_comb begin
    viol        = cmd_valid ? rule_hits(cmd, busy) : '0;
    viol[R_CKE] = cke_viol;
  end

  always_comb begin
    for (int c = 0; c < NUM_CMDS; c++)
      ready_mask[c] = (rule_hits(cmd_e'(c[CMD_W-1:0]), busy) == '0);
  end

endmodule

// File: rtl/ddr2_spacing_chk_sva.sv
module ddr2_spacing_chk_sva
  import ddr2_chk_pkg::*;
#(
  parameter int N_WTR = 2,
  parameter int N_RFC = 28,
  parameter int N_CKE = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [CMD_W-1:0]     cmd_code,
  input logic                 cke,
  input logic [NUM_RULES-1:0] viol,
  input logic [NUM_CMDS-1:0]  ready_mask
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  // R2: command rules fire only with a strobed command
  a_r2_quiet_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (viol[R_CKE-1:0] == '0));

  // R12: a command marked ready breaks no rule
  a_r12_ready_means_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code < CMD_W'(NUM_CMDS)) && ready_mask[cmd_code])
      |-> (viol[R_CKE-1:0] == '0));

  // R3: a read right after a write is always early
  a_r3_wtr_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ((N_WTR > 1) && (since_rst != 2'd0) && cmd_valid && (cmd_code == CMD_RD) &&
     $past(cmd_valid && ((cmd_code == CMD_WR) || (cmd_code == CMD_WRA))))
      |-> viol[R_WTR]);

  // R6: back-to-back refreshes are always early
  a_r6_ref_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ((N_RFC > 1) && (since_rst != 2'd0) && cmd_valid && (cmd_code == CMD_REF) &&
     $past(cmd_valid && (cmd_code == CMD_REF)))
      |-> viol[R_RFC]);

  // R11: CKE flag only on a level change
  a_r11_cke_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (viol[R_CKE] && (since_rst != 2'd0)) |-> (cke != $past(cke)));

  // R11: a one-clock CKE pulse is always flagged
  a_r11_cke_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((N_CKE > 1) && (since_rst >= 2'd2) && (cke != $past(cke)) && ($past(cke) != $past(cke, 2)))
      |-> viol[R_CKE]);

endmodule

bind ddr2_cmd_spacing_chk ddr2_spacing_chk_sva #(
  .N_WTR(N_WTR), .N_RFC(N_RFC), .N_CKE(CKE_CK)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cke        (cke),
  .viol       (viol),
  .ready_mask (ready_mask)
);

// File: tb/ddr2_cmd_spacing_chk_tb_top.sv
module ddr2_cmd_spacing_chk_tb_top;

  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD  = 4'd2, C_WR  = 4'd3,
                         C_WRA = 4'd4, C_PRE = 4'd5, C_REF = 4'd6, C_SRX = 4'd8,
                         C_PDX = 4'd10;
  localparam int B_WTR = 0, B_RTP = 1, B_DAL = 2, B_RFC = 3, B_XSNR = 4,
                 B_XSRD = 5, B_XP = 6, B_XARD = 7, B_CKE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_code;
  logic [2:0]  cmd_bank;
  logic        cke;
  logic [2:0]  add_lat;
  logic        pd_slow_exit;
  logic [8:0]  viol;
  logic [10:0] ready_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ddr2_cmd_spacing_chk dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cke(cke), .add_lat(add_lat), .pd_slow_exit(pd_slow_exit),
    .viol(viol), .ready_mask(ready_mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = C_NOP;
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [2:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    cmd_bank  = b;
  endtask

  // First command, then the second exactly `gap` clocks later; checks the
  // violation vector and the ready bit in the second command's cycle.
  task automatic pair(input string req, input logic [3:0] c1, input logic [2:0] b1,
                      input logic [3:0] c2, input logic [2:0] b2,
                      input int gap, input int bit_idx, input bit early);
    logic [8:0] exp;
    issue(c1, b1);
    for (int i = 1; i < gap; i++) idle(1);
    issue(c2, b2);
    #2;
    exp = early ? (9'd1 << bit_idx) : 9'd0;
    check(req, 32'(viol), 32'(exp));
    check({req, " ready"}, 32'(ready_mask[c2]), 32'(!early));
    idle(260);
  endtask

  task automatic t_reset;
    #2;
    check("R1 viol", 32'(viol), 32'd0);
    check("R1 ready", 32'(ready_mask), 32'h7FF);
  endtask

  task automatic t_no_valid;
    issue(C_WR, 3'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = C_RD;
    #2;
    check("R2 no strobe", 32'(viol), 32'd0);
    check("R12 read not ready", 32'(ready_mask[C_RD]), 32'd0);
    idle(20);
  endtask

  task automatic t_pd_precharge;
    pair("R9 xp legal", C_PDX, 3'd0, C_REF, 3'd0, 2, B_XP, 1'b0);
    pair("R9 xp early", C_PDX, 3'd0, C_REF, 3'd0, 1, B_XP, 1'b1);
  endtask

  task automatic t_pd_active;
    issue(C_ACT, 3'd0);
    idle(40);
    pd_slow_exit = 1'b0;
    add_lat      = 3'd0;
    pair("R10 fast legal", C_PDX, 3'd0, C_RD, 3'd0, 2, B_XARD, 1'b0);
    pair("R10 fast early", C_PDX, 3'd0, C_RD, 3'd0, 1, B_XARD, 1'b1);
    pd_slow_exit = 1'b1;
    add_lat      = 3'd1;
    pair("R10 slow al1 legal", C_PDX, 3'd0, C_RD, 3'd0, 5, B_XARD, 1'b0);
    pair("R10 slow al1 early", C_PDX, 3'd0, C_RD, 3'd0, 4, B_XARD, 1'b1);
    add_lat      = 3'd0;
    pair("R10 slow al0 early", C_PDX, 3'd0, C_RD, 3'd0, 5, B_XARD, 1'b1);
    add_lat      = 3'd7;
    pair("R10 slow al7 legal", C_PDX, 3'd0, C_RD, 3'd0, 1, B_XARD, 1'b0);
    pd_slow_exit = 1'b0;
    add_lat      = 3'd0;
    issue(C_PRE, 3'd0);
    idle(20);
  endtask

  task automatic t_wtr;
    pair("R3 wr legal", C_WR, 3'd0, C_RD, 3'd0, 2, B_WTR, 1'b0);
    pair("R3 wr early", C_WR, 3'd0, C_RD, 3'd0, 1, B_WTR, 1'b1);
    pair("R3 wra early", C_WRA, 3'd2, C_RD, 3'd2, 1, B_WTR, 1'b1);
  endtask

  task automatic t_rtp;
    pair("R4 rtp legal", C_RD, 3'd0, C_PRE, 3'd0, 2, B_RTP, 1'b0);
    pair("R4 rtp early", C_RD, 3'd0, C_PRE, 3'd0, 1, B_RTP, 1'b1);
  endtask

  task automatic t_dal;
    pair("R5 dal legal", C_WRA, 3'd3, C_ACT, 3'd3, 8, B_DAL, 1'b0);
    pair("R5 dal early", C_WRA, 3'd3, C_ACT, 3'd3, 7, B_DAL, 1'b1);
    pair("R5 other bank", C_WRA, 3'd3, C_ACT, 3'd5, 1, B_DAL, 1'b0);
    issue(C_PRE, 3'd3);
    idle(5);
    issue(C_PRE, 3'd5);
    idle(5);
  endtask

  task automatic t_rfc;
    pair("R6 ref-ref legal", C_REF, 3'd0, C_REF, 3'd0, 28, B_RFC, 1'b0);
    pair("R6 ref-ref early", C_REF, 3'd0, C_REF, 3'd0, 27, B_RFC, 1'b1);
    pair("R6 ref-act early", C_REF, 3'd0, C_ACT, 3'd1, 27, B_RFC, 1'b1);
    issue(C_PRE, 3'd1);
    idle(5);
  endtask

  task automatic t_selfref;
    pair("R7 xsnr legal", C_SRX, 3'd0, C_REF, 3'd0, 31, B_XSNR, 1'b0);
    pair("R7 xsnr early", C_SRX, 3'd0, C_REF, 3'd0, 30, B_XSNR, 1'b1);
    pair("R8 xsrd legal", C_SRX, 3'd0, C_RD, 3'd0, 200, B_XSRD, 1'b0);
    pair("R8 xsrd early", C_SRX, 3'd0, C_RD, 3'd0, 199, B_XSRD, 1'b1);
  endtask

  task automatic cke_pulse(input string req, input int gap, input bit early);
    @(negedge clk);
    cke = 1'b0;
    for (int i = 1; i < gap; i++) @(negedge clk);
    @(negedge clk);
    cke = 1'b1;
    #2;
    check(req, 32'(viol), early ? 32'(9'd1 << B_CKE) : 32'd0);
    idle(10);
  endtask

  task automatic t_cke;
    cke_pulse("R11 cke legal", 3, 1'b0);
    cke_pulse("R11 cke early", 2, 1'b1);
    cke_pulse("R11 cke one clock", 1, 1'b1);
  endtask

  initial begin
    rst_n        = 1'b0;
    cmd_valid    = 1'b0;
    cmd_code     = C_NOP;
    cmd_bank     = 3'd0;
    cke          = 1'b1;
    add_lat      = 3'd0;
    pd_slow_exit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_valid();
    t_pd_precharge();
    t_pd_active();
    t_wtr();
    t_rtp();
    t_dal();
    t_rfc();
    t_selfref();
    t_cke();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule